// File: doc/BRIEF.md
# SDRAM Command Issuer with Software-Armed Initialization

This block forms the command side of a small SDR-SDRAM controller. It has no hardware power-up sequencer. Software selects a command by writing a mode code into a control register. The next host write to the memory window then produces that SDRAM command on the pins in place of a data write. For the mode-set commands, the host address supplies the bank and row bits, so software chooses the mode value by the address it writes to. With the mode code at zero, each host write becomes an ordinary column write command.

A power-up pause counter blocks every host access until the required settling time has passed. The clock-enable pin stays low until the first NOP is issued. After each command the block waits a programmable number of cycles before it accepts the next access. A programmable refresh timer runs in normal mode. Each time it expires, the block issues a precharge-all followed by an auto-refresh, and any host access waits until both are done.

Top module: `sdram_cmd_issuer`

## Requirements
- R1: After reset the pins rest deselected (CS_n, RAS_n, CAS_n and WE_n all 1, BA and A all 0), CKE is 0, and hostReady stays 0 for PAUSE_CYC cycles before it rises.
- R2: Register port: select 0 holds the mode code in bits [2:0]; select 1 holds the refresh count in bits [15:0]; select 2 holds the precharge wait in bits [3:0], the refresh wait in bits [7:4] and the mode-set wait in bits [11:8]. A host write accepted (hostReq and hostReady high at an edge) puts exactly one command on the pins in the following cycle, chosen by mode code: 0 write, 1 NOP, 2 precharge all, 3 mode set, 4 auto-refresh, 5 extended mode set.
- R3: NOP drives {CS_n,RAS_n,CAS_n,WE_n} = 0111. CKE rises in the same cycle as the first NOP and never falls afterwards.
- R4: Precharge all drives 0010 with A[10] = 1.
- R5: Auto-refresh drives 0001, and repeated host writes in mode 4 each give one auto-refresh (eight in a row are accepted).
- R6: Mode set and extended mode set drive 0000. BA comes from host address bits [23:22] and A from host address bits [21:9].
- R7: A normal-mode write drives 0100 with BA from address bits [23:22], A from column bits [8:0] zero-extended, and A[10] = 0.
- R8: If a command is on the pins in cycle c, hostReady is 0 in cycle c and first returns in cycle c+1+T. T is the precharge wait for precharge, the refresh wait for auto-refresh, the mode-set wait for both mode sets, and 0 for NOP and write.
- R9: In mode 0 with a nonzero refresh count N, an automatic precharge-all is issued every N cycles. The auto-refresh follows 1+tRP cycles after it. A host write held during that sequence is issued only after the auto-refresh wait has ended.
- R10: A refresh count of 0 stops automatic refresh: no command appears without a host write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgWe | input | 1 | Register write strobe |
| cfgSel | input | 2 | Register select |
| cfgWdata | input | 16 | Register write data |
| hostReq | input | 1 | Host write access request |
| hostAddr | input | 24 | Host address: bank [23:22], row [21:9], column [8:0] |
| hostReady | output | 1 | Access accepted at an edge where hostReq is also high |
| sdCke | output | 1 | SDRAM clock enable |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdBa | output | 2 | Bank address |
| sdA | output | 13 | Address bus |

## Verification
The bench tests the power-up gate. A design whose pause counter is short or missing would acknowledge host writes early, and one that raises CKE too soon would show CKE high before any NOP. It measures the ready gap after each command class. A wrong wait selection would let the next access in too early or too late. It also checks A[10] on precharge and write, where a mistake would turn precharge-all into single-bank precharge or a write into an auto-precharge write. The refresh tests measure the refresh period, the precharge-to-refresh spacing and the stall of a host write held during refresh. They would catch an off-by-one reload, a refresh that slips in front of the host, or a timer that keeps firing after its count is set to zero.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;
  // command kinds; values 0..5 equal the software mode code that selects them
  typedef enum logic [2:0] {
    CMD_WR   = 3'd0,
    CMD_NOP  = 3'd1,
    CMD_PRE  = 3'd2,
    CMD_MRS  = 3'd3,
    CMD_REF  = 3'd4,
    CMD_EMRS = 3'd5
  } cmd_e;

  typedef struct packed {
    logic issue;     // drive a command on the pins at this edge
    cmd_e cmd;       // which command
    logic refTaken;  // the refresh sequence has started
  } strobe_t;
endpackage

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_cmd_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hostReq,
  input  logic [2:0]    modeCode,
  input  logic          pauseDone,
  input  logic          refPend,
  input  logic [TW-1:0] tRp,
  input  logic [TW-1:0] tRfc,
  input  logic [TW-1:0] tMrd,
  output logic          hostReady,
  output strobe_t       strb
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RPWAIT} state_e;

  state_e        state;
  logic [TW-1:0] waitCnt;

  function automatic logic [TW-1:0] waitFor(cmd_e c, logic [TW-1:0] rp,
                                            logic [TW-1:0] rfc, logic [TW-1:0] mrd);
    case (c)
      CMD_PRE:           return rp;
      CMD_REF:           return rfc;
      CMD_MRS, CMD_EMRS: return mrd;
      default:           return '0;
    endcase
  endfunction

  assign hostReady = (state == S_IDLE) && pauseDone && !refPend;

  always_comb begin
    strb = '{issue: 1'b0, cmd: CMD_NOP, refTaken: 1'b0};
    if (state == S_IDLE && pauseDone && refPend) begin
      strb.issue    = 1'b1;
      strb.cmd      = CMD_PRE;
      strb.refTaken = 1'b1;
    end else if (hostReady && hostReq) begin
      strb.issue = 1'b1;
      strb.cmd   = (modeCode > 3'd5) ? CMD_NOP : cmd_e'(modeCode);
    end else if (state == S_RPWAIT && waitCnt == '0) begin
      strb.issue = 1'b1;
      strb.cmd   = CMD_REF;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      waitCnt <= '0;
    end else if (strb.issue) begin
      if (strb.refTaken) begin
        state   <= S_RPWAIT;
        waitCnt <= tRp;
      end else begin
        state   <= S_WAIT;
        waitCnt <= waitFor(strb.cmd, tRp, tRfc, tMrd);
      end
    end else if (state == S_WAIT) begin
      if (waitCnt == '0) state <= S_IDLE;
      else               waitCnt <= waitCnt - 1'b1;
    end else if (state == S_RPWAIT) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end
endmodule

// File: rtl/sdram_cmd_dp.sv
module sdram_cmd_dp
  import sdram_cmd_pkg::*;
#(
  parameter int COL_W     = 9,
  parameter int ROW_W     = 13,
  parameter int BANK_W    = 2,
  parameter int REF_W     = 16,
  parameter int TW        = 4,
  parameter int CFG_W     = 16,
  parameter int PAUSE_CYC = 20000
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfgWe,
  input  logic [1:0]                    cfgSel,
  input  logic [CFG_W-1:0]              cfgWdata,
  input  logic [COL_W+ROW_W+BANK_W-1:0] hostAddr,
  input  strobe_t                       strb,
  output logic [2:0]                    modeCode,
  output logic [TW-1:0]                 tRp,
  output logic [TW-1:0]                 tRfc,
  output logic [TW-1:0]                 tMrd,
  output logic                          pauseDone,
  output logic                          refPend,
  output logic                          cke,
  output logic [3:0]                    pins,
  output logic [BANK_W-1:0]             ba,
  output logic [ROW_W-1:0]              a
);
  localparam int PAUSE_W = $clog2(PAUSE_CYC + 1);
  localparam int AP_BIT  = 10;

  logic [PAUSE_W-1:0] pauseCnt;
  logic [REF_W-1:0]   refField, refTimer;
  logic               refRun, refTick;
  logic [COL_W-1:0]   col;
  logic [ROW_W-1:0]   row, colExt;
  logic [BANK_W-1:0]  bank;

  assign col  = hostAddr[COL_W-1:0];
  assign row  = hostAddr[COL_W +: ROW_W];
  assign bank = hostAddr[COL_W+ROW_W +: BANK_W];

  always_comb begin
    colExt         = ROW_W'(col);
    colExt[AP_BIT] = 1'b0;
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      modeCode <= '0;
      tRp      <= '0;
      tRfc     <= '0;
      tMrd     <= '0;
    end else if (cfgWe) begin
      if (cfgSel == 2'd0) modeCode <= cfgWdata[2:0];
      if (cfgSel == 2'd2) begin
        tRp  <= cfgWdata[TW-1:0];
        tRfc <= cfgWdata[2*TW-1:TW];
        tMrd <= cfgWdata[3*TW-1:2*TW];
      end
    end
  end

  // power-up pause
  assign pauseDone = (pauseCnt == PAUSE_W'(PAUSE_CYC));
  always_ff @(posedge clk) begin
    if (rst)             pauseCnt <= '0;
    else if (!pauseDone) pauseCnt <= pauseCnt + 1'b1;
  end

  // refresh timer
  assign refRun  = (modeCode == 3'd0) && pauseDone && (refField != '0);
  assign refTick = refRun && (refTimer <= REF_W'(1));
  always_ff @(posedge clk) begin
    if (rst) begin
      refField <= '0;
      refTimer <= '0;
      refPend  <= 1'b0;
    end else begin
      if (cfgWe && cfgSel == 2'd1) begin
        refField <= cfgWdata[REF_W-1:0];
        refTimer <= cfgWdata[REF_W-1:0];
      end else if (refRun) begin
        refTimer <= refTick ? refField : refTimer - 1'b1;
      end
      if (strb.refTaken) refPend <= 1'b0;
      if (refTick)       refPend <= 1'b1;
    end
  end

  // command pins: {cs_n, ras_n, cas_n, we_n}
  always_ff @(posedge clk) begin
    if (rst) begin
      cke  <= 1'b0;
      pins <= 4'b1111;
      ba   <= '0;
      a    <= '0;
    end else begin
      pins <= 4'b1111;
      ba   <= '0;
      a    <= '0;
      if (strb.issue) begin
        case (strb.cmd)
          CMD_PRE: begin
            pins      <= 4'b0010;
            a[AP_BIT] <= 1'b1;
          end
          CMD_REF: pins <= 4'b0001;
          CMD_MRS, CMD_EMRS: begin
            pins <= 4'b0000;
            ba   <= bank;
            a    <= row;
          end
          CMD_WR: begin
            pins <= 4'b0100;
            ba   <= bank;
            a    <= colExt;
          end
          default: pins <= 4'b0111;
        endcase
      end
      cke <= cke | (strb.issue && strb.cmd == CMD_NOP);
    end
  end
endmodule

// File: rtl/sdram_cmd_issuer.sv
module sdram_cmd_issuer
  import sdram_cmd_pkg::*;
#(
  parameter int COL_W     = 9,
  parameter int ROW_W     = 13,
  parameter int BANK_W    = 2,
  parameter int REF_W     = 16,
  parameter int TW        = 4,
  parameter int CFG_W     = 16,
  parameter int PAUSE_CYC = 20000
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfgWe,
  input  logic [1:0]                    cfgSel,
  input  logic [CFG_W-1:0]              cfgWdata,
  input  logic                          hostReq,
  input  logic [COL_W+ROW_W+BANK_W-1:0] hostAddr,
  output logic                          hostReady,
  output logic                          sdCke,
  output logic                          sdCsN,
  output logic                          sdRasN,
  output logic                          sdCasN,
  output logic                          sdWeN,
  output logic [BANK_W-1:0]             sdBa,
  output logic [ROW_W-1:0]              sdA
);
  strobe_t       strb;
  logic [2:0]    modeCode;
  logic [TW-1:0] tRp, tRfc, tMrd;
  logic          pauseDone, refPend;
  logic [3:0]    pins;

  sdram_cmd_ctrl #(.TW(TW)) u_ctrl (
    .clk(clk), .rst(rst), .hostReq(hostReq), .modeCode(modeCode),
    .pauseDone(pauseDone), .refPend(refPend), .tRp(tRp), .tRfc(tRfc),
    .tMrd(tMrd), .hostReady(hostReady), .strb(strb)
  );

  sdram_cmd_dp #(
    .COL_W(COL_W), .ROW_W(ROW_W), .BANK_W(BANK_W), .REF_W(REF_W),
    .TW(TW), .CFG_W(CFG_W), .PAUSE_CYC(PAUSE_CYC)
  ) u_dp (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .hostAddr(hostAddr), .strb(strb), .modeCode(modeCode), .tRp(tRp),
    .tRfc(tRfc), .tMrd(tMrd), .pauseDone(pauseDone), .refPend(refPend),
    .cke(sdCke), .pins(pins), .ba(sdBa), .a(sdA)
  );

  assign {sdCsN, sdRasN, sdCasN, sdWeN} = pins;
endmodule

// File: rtl/sdram_cmd_chk.sv
module sdram_cmd_chk #(
  parameter int ROW_W     = 13,
  parameter int PAUSE_CYC = 20000
) (
  input logic             clk,
  input logic             rst,
  input logic             hostReq,
  input logic             hostReady,
  input logic             sdCke,
  input logic             sdCsN,
  input logic             sdRasN,
  input logic             sdCasN,
  input logic             sdWeN,
  input logic [ROW_W-1:0] sdA
);
  localparam int CW = $clog2(PAUSE_CYC + 1);
  logic [CW-1:0] sinceRst;
  logic [3:0]    pinVec;

  assign pinVec = {sdCsN, sdRasN, sdCasN, sdWeN};

  always_ff @(posedge clk) begin
    if (rst)                              sinceRst <= '0;
    else if (sinceRst != CW'(PAUSE_CYC))  sinceRst <= sinceRst + 1'b1;
  end

  // R1
  pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sinceRst < CW'(PAUSE_CYC)) |-> !hostReady);

  // R2
  accept_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (hostReady && hostReq) |=> !sdCsN);

  // R3
  cke_hold_chk: assert property (@(posedge clk) disable iff (rst)
    sdCke |=> sdCke);

  // R3
  cke_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sdCke) |-> (pinVec == 4'b0111));

  // R4
  pre_all_chk: assert property (@(posedge clk) disable iff (rst)
    (pinVec == 4'b0010) |-> sdA[10]);

  // R7
  wr_no_ap_chk: assert property (@(posedge clk) disable iff (rst)
    (pinVec == 4'b0100) |-> !sdA[10]);

  // R8
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    !sdCsN |-> !hostReady);
endmodule

bind sdram_cmd_issuer sdram_cmd_chk #(.ROW_W(ROW_W), .PAUSE_CYC(PAUSE_CYC)) u_chk (
  .clk(clk), .rst(rst), .hostReq(hostReq), .hostReady(hostReady),
  .sdCke(sdCke), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN),
  .sdWeN(sdWeN), .sdA(sdA)
);

// File: tb/sdram_cmd_issuer_tb.sv
module sdram_cmd_issuer_tb;
  localparam int TP    = 10;
  localparam int PAUSE = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [15:0] cfgWdata = '0;
  logic        hostReq = 1'b0;
  logic [23:0] hostAddr = '0;
  logic        hostReady, sdCke, sdCsN, sdRasN, sdCasN, sdWeN;
  logic [1:0]  sdBa;
  logic [12:0] sdA;

  int cyc = 0;
  int errors = 0;
  int checks = 0;
  int cmdCyc = 0;

  always #(TP/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_cmd_issuer #(.PAUSE_CYC(PAUSE)) u_dut (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .hostReq(hostReq), .hostAddr(hostAddr), .hostReady(hostReady),
    .sdCke(sdCke), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN),
    .sdWeN(sdWeN), .sdBa(sdBa), .sdA(sdA)
  );

  function automatic logic [3:0] pinsNow();
    return {sdCsN, sdRasN, sdCasN, sdWeN};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at cycle %0d", req, got, exp, cyc);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgWdata = data;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // waits for ready, issues one access, returns sampled in the command cycle
  task automatic hostWrite(input logic [23:0] addr);
    int n = 0;
    @(negedge clk);
    while (!hostReady && n < 2000) begin @(negedge clk); n++; end
    hostAddr = addr; hostReq = 1'b1;
    @(negedge clk);
    hostReq = 1'b0;
    cmdCyc = cyc;
  endtask

  task automatic gapCheck(input string req, input int expGap);
    int k = 0;
    while (!hostReady && k < 100) begin @(negedge clk); k++; end
    check(req, k, expGap);
  endtask

  task automatic waitPins(input logic [3:0] want, output int at);
    int n = 0;
    @(negedge clk);
    while (pinsNow() != want && n < 500) begin @(negedge clk); n++; end
    at = cyc;
  endtask

  task automatic t_reset();
    int n = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 pins after reset", {pinsNow(), 2'b0, sdBa, 3'b0, sdA}, {4'b1111, 20'h0});
    check("R1 cke after reset", sdCke, 0);
    check("R1 ready during pause", hostReady, 0);
    repeat (PAUSE - 6) @(negedge clk);
    check("R1 ready late in pause", hostReady, 0);
    while (!hostReady && n < 20) begin @(negedge clk); n++; end
    check("R1 ready after pause", hostReady, 1);
  endtask

  task automatic t_nop();
    cfgWrite(2'd2, 16'h0231);   // tMrd=2 tRfc=3 tRp=1
    cfgWrite(2'd0, 16'd1);
    check("R3 cke low before NOP", sdCke, 0);
    hostWrite(24'h0);
    check("R3 NOP pins", pinsNow(), 4'b0111);
    check("R3 cke high with NOP", sdCke, 1);
    gapCheck("R8 NOP gap", 1);
  endtask

  task automatic t_pre();
    cfgWrite(2'd0, 16'd2);
    hostWrite(24'h0);
    check("R4 precharge pins", pinsNow(), 4'b0010);
    check("R4 precharge A10", sdA[10], 1);
    gapCheck("R8 precharge gap", 2);
  endtask

  task automatic t_ref8();
    int good = 0;
    cfgWrite(2'd0, 16'd4);
    for (int i = 0; i < 8; i++) begin
      hostWrite(24'h0);
      if (pinsNow() == 4'b0001) good++;
      if (i == 0) gapCheck("R8 refresh gap", 4);
    end
    check("R5 eight auto-refresh", good, 8);
  endtask

  task automatic t_mrs();
    cfgWrite(2'd0, 16'd3);
    hostWrite({2'b00, 13'h0033, 9'h000});
    check("R6 MRS pins", pinsNow(), 4'b0000);
    check("R6 MRS bank", sdBa, 0);
    check("R6 MRS value", sdA, 13'h0033);
    gapCheck("R8 MRS gap", 3);
    cfgWrite(2'd0, 16'd5);
    hostWrite({2'b10, 13'h0020, 9'h000});
    check("R6 EMRS pins", pinsNow(), 4'b0000);
    check("R6 EMRS bank", sdBa, 2);
    check("R6 EMRS value", sdA, 13'h0020);
  endtask

  task automatic t_write();
    cfgWrite(2'd0, 16'd0);
    hostWrite({2'b01, 13'h1FFF, 9'h1AB});
    check("R7 write pins", pinsNow(), 4'b0100);
    check("R7 write bank", sdBa, 1);
    check("R7 write column", sdA, 13'h01AB);
    gapCheck("R8 write gap", 1);
  endtask

  task automatic t_refresh();
    int c1, c2, c3, c4, n;
    cfgWrite(2'd2, 16'h0232);   // tMrd=2 tRfc=3 tRp=2
    cfgWrite(2'd1, 16'd50);
    waitPins(4'b0010, c1);
    waitPins(4'b0001, c2);
    check("R9 precharge to refresh", c2 - c1, 3);
    waitPins(4'b0010, c3);
    check("R9 refresh period", c3 - c1, 50);
    waitPins(4'b0010, c4);
    hostAddr = {2'b11, 13'h0, 9'h005};
    hostReq = 1'b1;
    n = 0;
    while (!hostReady && n < 100) begin @(negedge clk); n++; end
    @(negedge clk);
    hostReq = 1'b0;
    check("R9 stalled write pins", pinsNow(), 4'b0100);
    check("R9 stalled write cycle", cyc - c4, 8);
  endtask

  task automatic t_disable();
    int seen = 0;
    cfgWrite(2'd1, 16'd0);
    repeat (10) @(negedge clk);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!sdCsN) seen++;
    end
    check("R10 no refresh when count zero", seen, 0);
    check("R3 cke still high", sdCke, 1);
  endtask

  initial begin
    #(TP * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_nop();
    t_pre();
    t_ref8();
    t_mrs();
    t_write();
    t_refresh();
    t_disable();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule